// File: doc/BRIEF.md
# Link-Aware Fast Reroute Port Resolver

This block sits directly after a route lookup. It takes the port field of the matched route entry and returns a one-hot egress decision. The field holds two 8-bit one-hot port masks: a preferred (primary) mask and a fallback (backup) mask. Each decision is made from live link-up status reported by the physical-layer devices. When the primary link fails, traffic moves to the backup port with no software action and no table rewrite. A neighbour that has frozen but still holds its link up cannot be seen by this mechanism.

Each accepted request is one packet decision. The link vector is read at the moment the request is accepted and never afterwards. A decision that is already registered therefore stays fixed until the output-queue stage takes it, even if a link changes in the meantime. Results leave through one registered stage with a valid/ready handshake.

Top module: `frr_port_resolver`

## Requirements
- R1: When the primary mask has a bit set on a live port, the output is the primary mask and both flags (`dec_failover`, `dec_no_route`) are 0.
- R2: When the primary port is not live and the backup mask is nonzero with a live port, the output is the backup mask, `dec_failover` is 1 and `dec_no_route` is 0.
- R3: When neither the primary nor a nonzero backup port is live, the output is the primary mask, `dec_no_route` is 1 and `dec_failover` is 0.
- R4: An all-zero backup mask means no backup. With a dead primary, the primary mask is output unchanged with `dec_no_route` = 1.
- R5: Port mask bit 2i is MAC port i and takes its liveness from `phy_link_up[i]`. Bit 2i+1 is CPU port i and is always live.
- R6: `phy_link_up` passes through two flops. A value present at clock edge k is used by decisions accepted at edge k+2 and later. Decisions accepted at edge k or k+1 use the older value.
- R7: `req_ready` equals `!dec_valid || dec_ready`. `dec_valid` rises on the edge that follows an accepted request, one cycle after acceptance.
- R8: While `dec_valid` is 1 and `dec_ready` is 0, the decision outputs stay stable, regardless of any link changes, and `req_ready` is 0.
- R9: After reset, `dec_valid` is 0 and `req_ready` is 1.
- R10: In `req_port_field`, bits [7:0] are the primary mask and bits [15:8] are the backup mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phy_link_up | input | 4 | Link-up per MAC port, asynchronous to clk |
| req_valid | input | 1 | Route entry port field is present |
| req_ready | output | 1 | Resolver can accept a request |
| req_port_field | input | 16 | {backup mask, primary mask} |
| dec_valid | output | 1 | Decision available |
| dec_ready | input | 1 | Output-queue stage takes the decision |
| dec_ports | output | 8 | One-hot chosen egress port |
| dec_failover | output | 1 | Backup mask was chosen |
| dec_no_route | output | 1 | No live port in the entry |

## Verification
The assertions assume that each port mask in a request is one-hot or zero. They also assume that `req_port_field` is held stable while `req_valid` is high and the request is not yet accepted. The stimulus only uses single-bit or empty masks. It changes request fields only on the falling edge after a handshake has completed. Link status is changed either well ahead of a request or on purpose inside the two-cycle window, so that the old or new value can be predicted exactly.

// File: rtl/frr_pkg.sv
package frr_pkg;
  typedef enum logic [1:0] {
    PICK_PRIMARY = 2'd0,
    PICK_BACKUP  = 2'd1,
    PICK_NONE    = 2'd2
  } pick_e;

  localparam int unsigned DEF_MASK_W   = 8;
  localparam int unsigned DEF_SYNC_LEN = 2;
endpackage

// File: rtl/frr_link_sync.sv
module frr_link_sync #(
  parameter int unsigned LINKS = 4,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINKS-1:0] link_raw,
  output logic [LINKS-1:0] link_safe
);
  logic [LINKS-1:0] chain [DEPTH];
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= link_raw;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
    // R6: each stage carries the previous stage forward by one cycle
    a_r6_stage_shift: assert property (@(posedge clk) disable iff (rst)
      armed |-> chain[s] == $past(chain[s-1]));
  end

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R6: first stage captures the raw input
  a_r6_first_capture: assert property (@(posedge clk) disable iff (rst)
    armed |-> chain[0] == $past(link_raw));

  assign link_safe = chain[DEPTH-1];
endmodule

// File: rtl/frr_live_map.sv
module frr_live_map #(
  parameter int unsigned MASK_W = 8
) (
  input  logic [MASK_W/2-1:0] mac_up,
  output logic [MASK_W-1:0]   port_live
);
  localparam int unsigned PAIRS = MASK_W / 2;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign port_live[2*p]   = mac_up[p];
    assign port_live[2*p+1] = 1'b1;
  end
endmodule

// File: rtl/frr_path_select.sv
module frr_path_select
  import frr_pkg::*;
#(
  parameter int unsigned MASK_W = 8
) (
  input  logic [2*MASK_W-1:0] port_field,
  input  logic [MASK_W-1:0]   port_live,
  output logic [MASK_W-1:0]   chosen,
  output pick_e               pick
);
  logic [MASK_W-1:0] prim_mask;
  logic [MASK_W-1:0] back_mask;
  logic              prim_alive;
  logic              back_alive;
  logic              back_present;

  assign prim_mask    = port_field[MASK_W-1:0];
  assign back_mask    = port_field[2*MASK_W-1:MASK_W];
  assign prim_alive   = |(prim_mask & port_live);
  assign back_alive   = |(back_mask & port_live);
  assign back_present = |back_mask;

  always_comb begin
    chosen = prim_mask;
    pick   = PICK_PRIMARY;
    if (!prim_alive) begin
      if (back_present && back_alive) begin
        chosen = back_mask;
        pick   = PICK_BACKUP;
      end else begin
        pick   = PICK_NONE;
      end
    end
  end
endmodule

// File: rtl/frr_out_stage.sv
module frr_out_stage
  import frr_pkg::*;
#(
  parameter int unsigned MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MASK_W-1:0] in_ports,
  input  pick_e             in_pick,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [MASK_W-1:0] out_ports,
  output logic              out_failover,
  output logic              out_no_route
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_ports    <= '0;
      out_failover <= 1'b0;
      out_no_route <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_ports    <= in_ports;
        out_failover <= (in_pick == PICK_BACKUP);
        out_no_route <= (in_pick == PICK_NONE);
      end
    end
  end

  // R8: a stalled decision is held unchanged
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_ports)
      && $stable(out_failover) && $stable(out_no_route));

  // R7: valid appears only after an accepted request
  a_r7_valid_source: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

// File: rtl/frr_port_resolver.sv
module frr_port_resolver
  import frr_pkg::*;
#(
  parameter int unsigned MASK_W   = DEF_MASK_W,
  parameter int unsigned SYNC_LEN = DEF_SYNC_LEN
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [MASK_W/2-1:0] phy_link_up,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [2*MASK_W-1:0] req_port_field,
  output logic                dec_valid,
  input  logic                dec_ready,
  output logic [MASK_W-1:0]   dec_ports,
  output logic                dec_failover,
  output logic                dec_no_route
);
  localparam int unsigned MACS = MASK_W / 2;

  logic [MACS-1:0]   mac_safe;
  logic [MASK_W-1:0] live;
  logic [MASK_W-1:0] sel_ports;
  pick_e             sel_pick;

  frr_link_sync #(.LINKS(MACS), .DEPTH(SYNC_LEN)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .link_raw  (phy_link_up),
    .link_safe (mac_safe)
  );

  frr_live_map #(.MASK_W(MASK_W)) u_map (
    .mac_up    (mac_safe),
    .port_live (live)
  );

  frr_path_select #(.MASK_W(MASK_W)) u_sel (
    .port_field (req_port_field),
    .port_live  (live),
    .chosen     (sel_ports),
    .pick       (sel_pick)
  );

  frr_out_stage #(.MASK_W(MASK_W)) u_out (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (req_valid),
    .in_ready     (req_ready),
    .in_ports     (sel_ports),
    .in_pick      (sel_pick),
    .out_valid    (dec_valid),
    .out_ready    (dec_ready),
    .out_ports    (dec_ports),
    .out_failover (dec_failover),
    .out_no_route (dec_no_route)
  );

  // R1: live primary is forwarded unchanged with no flags
  a_r1_primary_kept: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && |(req_port_field[MASK_W-1:0] & live)
      |=> dec_valid && dec_ports == $past(req_port_field[MASK_W-1:0])
          && !dec_failover && !dec_no_route);

  // R2: a failover decision carries the backup mask
  a_r2_backup_used: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !(|(req_port_field[MASK_W-1:0] & live))
      && |(req_port_field[2*MASK_W-1:MASK_W] & live)
      |=> dec_failover && dec_ports == $past(req_port_field[2*MASK_W-1:MASK_W]));

  // R3: the two flags never appear together
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> !(dec_failover && dec_no_route));

  // R7: req_ready follows the output stage occupancy
  a_r7_ready_rule: assert property (@(posedge clk) disable iff (rst)
    req_ready == (!dec_valid || dec_ready));
endmodule

// File: tb/frr_port_resolver_tb.sv
`timescale 1ns/100ps
module frr_port_resolver_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  phy_link_up = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_port_field = '0;
  logic        dec_valid;
  logic        dec_ready = 1'b1;
  logic [7:0]  dec_ports;
  logic        dec_failover;
  logic        dec_no_route;

  int total = 0;
  int bad   = 0;
  int pushed = 0;
  int popped = 0;

  typedef struct {
    logic [7:0] ports;
    logic       fo;
    logic       nr;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  frr_port_resolver u_dut (
    .clk(clk), .rst(rst), .phy_link_up(phy_link_up),
    .req_valid(req_valid), .req_ready(req_ready), .req_port_field(req_port_field),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_ports(dec_ports),
    .dec_failover(dec_failover), .dec_no_route(dec_no_route)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: bit 2i live from links[i], odd bits always live.
  function automatic exp_t model(input logic [15:0] f, input logic [3:0] links, input string tag);
    exp_t e;
    logic [7:0] live, pm, bm;
    for (int i = 0; i < 4; i++) begin
      live[2*i]   = links[i];
      live[2*i+1] = 1'b1;
    end
    pm = f[7:0];
    bm = f[15:8];
    e.tag = tag;
    if ((pm & live) != 0) begin
      e.ports = pm; e.fo = 0; e.nr = 0;
    end else if (bm != 0 && (bm & live) != 0) begin
      e.ports = bm; e.fo = 1; e.nr = 0;
    end else begin
      e.ports = pm; e.fo = 0; e.nr = 1;
    end
    return e;
  endfunction

  // Driver: starts and ends on a falling edge.
  task automatic send(input logic [15:0] f, input logic [3:0] model_links, input string tag);
    req_valid      = 1'b1;
    req_port_field = f;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    sb.push_back(model(f, model_links, tag));
    pushed++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops an expected item whenever a decision is taken.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && dec_valid && dec_ready) begin
        if (sb.size() == 0) begin
          check(0, "R7 unexpected decision", {24'd0, dec_ports}, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          popped++;
          check(dec_ports == e.ports, {e.tag, " ports"}, {24'd0, dec_ports}, {24'd0, e.ports});
          check(dec_failover == e.fo && dec_no_route == e.nr, {e.tag, " flags"},
                {30'd0, dec_failover, dec_no_route}, {30'd0, e.fo, e.nr});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R9 reset state
    check(dec_valid == 0, "R9 dec_valid after reset", {31'd0, dec_valid}, 0);
    check(req_ready == 1, "R9 req_ready after reset", {31'd0, req_ready}, 1);

    phy_link_up = 4'b1111;
    idle(3);
    // R1 and R10: primary MAC1 (bit 2) in [7:0], backup MAC2 (bit 4) in [15:8]
    send(16'h1004, 4'b1111, "R1 R10 primary live");
    // R7: decision valid right after the accept edge
    #1;
    check(dec_valid == 1, "R7 one-cycle latency", {31'd0, dec_valid}, 1);
    idle(1);

    // R2: MAC1 down, backup MAC2 up
    phy_link_up = 4'b1101;
    idle(3);
    send(16'h1004, 4'b1101, "R2 failover to backup");
    // R3: both down
    phy_link_up = 4'b1001;
    idle(3);
    send(16'h1004, 4'b1001, "R3 no live route");
    // R4: empty backup, dead primary
    send(16'h0004, 4'b1001, "R4 empty backup");
    // R5: CPU1 (bit 3) primary is always live even with all links down
    phy_link_up = 4'b0000;
    idle(3);
    send(16'h0008, 4'b0000, "R5 cpu primary always live");
    // R5: CPU0 backup used when MAC0 primary is dead
    send(16'h0201, 4'b0000, "R5 cpu backup");
    // R10: primary MAC3 (bit 6) down, backup MAC0 (bit 0) up
    phy_link_up = 4'b0001;
    idle(3);
    send(16'h0140, 4'b0001, "R10 field positions");

    // R6: link change on the same falling edge as the request
    phy_link_up = 4'b1111;
    idle(3);
    phy_link_up = 4'b1110;
    send(16'h0401, 4'b1111, "R6 edge k uses old link");
    send(16'h0401, 4'b1111, "R6 edge k+1 uses old link");
    send(16'h0401, 4'b1110, "R6 edge k+2 uses new link");
    idle(2);

    // R8: stall with link change
    phy_link_up = 4'b1111;
    idle(3);
    dec_ready = 1'b0;
    send(16'h1004, 4'b1111, "R8 stalled decision");
    held = dec_ports;
    phy_link_up = 4'b0000;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      #1;
      check(dec_valid == 1 && dec_ports == held && !dec_failover && !dec_no_route,
            "R8 held during stall", {24'd0, dec_ports}, {24'd0, held});
      check(req_ready == 0, "R8 req_ready low in stall", {31'd0, req_ready}, 0);
    end
    @(negedge clk);
    dec_ready = 1'b1;
    idle(4);
    check(dec_valid == 0, "R7 drained", {31'd0, dec_valid}, 0);
    check(popped == pushed && sb.size() == 0, "R7 all decisions delivered", popped, pushed);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule